// File: doc/BRIEF.md
# Idle Standby Countdown Timer

This block watches for a quiet system. Software stores an initial count and then sets a run bit; from that moment the counter steps down by one on every pulse of a slow time-base strobe (one pulse per 8 seconds in the intended system). With an 8-bit count, the longest timeout is about 34 minutes. When the count runs out, the block raises a one-clock SMI request and sets a sticky idle status flag. It then reloads the initial count and carries on counting.

Any sign of activity restarts the wait. A set of event lines (interrupt lines, INTR, ring indicate, NMI, battery-low/suspend button, SMI and external SMI) can each be allowed to reload the counter. A global enable sits above that mask. A separate system-activity line reloads the counter unconditionally. A freeze input holds the count. The time-base generator and the gating of the SMI request onto the processor pin lie outside this block.

Top module: `idle_standby_timer`

## Requirements
- R1: After reset, `smi_req_o` and `idle_sts_o` are 0 and the timer is stopped, so ticks cause no expiry.
- R2: A cycle with `run_we_i`=1 and `run_wdata_i`=1 starts the timer and loads the counter from the initial count. If `init_we_i` is 1 in the same cycle, the value on `init_wdata_i` is used.
- R3: While running, an initial count N≥1 expires on the N-th accepted tick after the load. An initial count of 0 expires on the first accepted tick.
- R4: On expiry, `smi_req_o` is 1 for exactly the one cycle after the clock edge that accepted the expiring tick, and `idle_sts_o` becomes 1 in that same cycle. The counter reloads, and the next expiry follows after another N ticks.
- R5: `idle_sts_o` stays 1 until a cycle with `sts_clr_i`=1, after which it reads 0.
- R6: In every cycle where `evt_i[k]`, `evt_en_i[k]` and `evt_all_en_i` are all 1, the counter is reloaded from the initial count.
- R7: An event line whose `evt_en_i` bit is 0, or any event line while `evt_all_en_i` is 0, does not reload the counter.
- R8: `activity_i`=1 reloads the counter regardless of `evt_all_en_i` and `evt_en_i`.
- R9: While `freeze_i` is 1, ticks are ignored and the count is held. Counting resumes from the held value once `freeze_i` returns to 0.
- R10: A reload in the same cycle as a tick wins. That tick neither decrements the counter nor causes an expiry.
- R11: A cycle with `run_we_i`=1 and `run_wdata_i`=0 stops the timer, and no expiry follows however many ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base strobe, one cycle per tick |
| freeze_i | input | 1 | Holds the count while 1 |
| activity_i | input | 1 | System activity, always reloads |
| evt_i | input | NEV (19) | System event lines, level active |
| evt_en_i | input | NEV (19) | Per-event reload enables |
| evt_all_en_i | input | 1 | Global enable for the event reloads |
| init_we_i | input | 1 | Write strobe for the initial count |
| init_wdata_i | input | CW (8) | Initial count write data |
| run_we_i | input | 1 | Write strobe for the run bit |
| run_wdata_i | input | 1 | Run bit write data (1 starts and reloads) |
| sts_clr_i | input | 1 | Write-1-to-clear strobe for the idle status |
| smi_req_o | output | 1 | One-cycle SMI request per expiry |
| idle_sts_o | output | 1 | Sticky idle status |

## Verification
Every result lands one clock after its cause. The SMI pulse and the status flag appear in the cycle after the edge that took the expiring tick. A reload takes effect at the edge that samples the event, so the count of ticks to the next expiry starts afresh from the tick after it. The bench drives each strobe for exactly one cycle from the falling edge and samples the outputs at the next falling edge. For every tick of a countdown it checks the SMI request, expecting 0 before the N-th tick and 1 on it. This exposes both early and late expiry and any reload that should or should not have happened.

// File: rtl/idle_standby_timer.sv
module idle_standby_timer #(
  parameter int CW  = 8,
  parameter int NEV = 19
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_i,
  input  logic           freeze_i,
  input  logic           activity_i,
  input  logic [NEV-1:0] evt_i,
  input  logic [NEV-1:0] evt_en_i,
  input  logic           evt_all_en_i,
  input  logic           init_we_i,
  input  logic [CW-1:0]  init_wdata_i,
  input  logic           run_we_i,
  input  logic           run_wdata_i,
  input  logic           sts_clr_i,
  output logic           smi_req_o,
  output logic           idle_sts_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] init_q, cnt_q, load_val;
  logic          run_q, smi_q, sts_q;
  logic          ev_hit, start, ext_reload, step, expire;

  assign load_val   = init_we_i ? init_wdata_i : init_q;
  assign ev_hit     = evt_all_en_i & |(evt_i & evt_en_i);
  assign start      = run_we_i & run_wdata_i;
  assign ext_reload = start | activity_i | ev_hit;
  assign step       = run_q & tick_i & ~freeze_i & ~ext_reload;
  assign expire     = step & (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= '0;
      run_q  <= 1'b0;
    end else begin
      if (init_we_i) init_q <= init_wdata_i;
      if (run_we_i)  run_q  <= run_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (ext_reload | expire) cnt_q <= load_val;
    else if (step)                cnt_q <= cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smi_q <= 1'b0;
      sts_q <= 1'b0;
    end else begin
      smi_q <= expire;
      if (expire)         sts_q <= 1'b1;
      else if (sts_clr_i) sts_q <= 1'b0;
    end
  end

  assign smi_req_o  = smi_q;
  assign idle_sts_o = sts_q;

  AST_SMI_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req_o |-> idle_sts_o); // R4

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_sts_o && !sts_clr_i) |=> idle_sts_o); // R5

  AST_STOPPED_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start) |=> !smi_req_o); // R11

  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !activity_i && !run_we_i && !ev_hit) |=> $stable(cnt_q)); // R9

  AST_ACTIVITY_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    activity_i |=> (cnt_q == $past(load_val))); // R8

  AST_GLOBAL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_all_en_i && !activity_i && !run_we_i && !tick_i) |=> $stable(cnt_q)); // R7

  AST_RELOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && (activity_i || ev_hit)) |=> !smi_req_o); // R10

endmodule

// File: tb/test_idle_standby_timer.sv
module test_idle_standby_timer;
  localparam int CW  = 8;
  localparam int NEV = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 0, freeze_i = 0, activity_i = 0;
  logic [NEV-1:0] evt_i = '0, evt_en_i = '0;
  logic evt_all_en_i = 0, init_we_i = 0, run_we_i = 0, run_wdata_i = 0, sts_clr_i = 0;
  logic [CW-1:0] init_wdata_i = '0;
  logic smi_req_o, idle_sts_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  idle_standby_timer #(.CW(CW), .NEV(NEV)) i_idle_standby_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
    .activity_i(activity_i), .evt_i(evt_i), .evt_en_i(evt_en_i),
    .evt_all_en_i(evt_all_en_i), .init_we_i(init_we_i), .init_wdata_i(init_wdata_i),
    .run_we_i(run_we_i), .run_wdata_i(run_wdata_i), .sts_clr_i(sts_clr_i),
    .smi_req_o(smi_req_o), .idle_sts_o(idle_sts_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_init(input logic [CW-1:0] v);
    init_we_i = 1; init_wdata_i = v; cyc(); init_we_i = 0;
  endtask

  task automatic wr_run(input logic b);
    run_we_i = 1; run_wdata_i = b; cyc(); run_we_i = 0;
  endtask

  task automatic one_tick(output logic s);
    tick_i = 1; cyc(); tick_i = 0; s = smi_req_o;
  endtask

  task automatic ticks_expect(input int n, input string what);
    logic s;
    for (int i = 1; i <= n; i++) begin
      one_tick(s);
      chk(s, (i == n), $sformatf("%s tick %0d", what, i));
    end
  endtask

  task automatic ticks_none(input int n, input string what);
    logic s;
    for (int i = 1; i <= n; i++) begin
      one_tick(s);
      chk(s, 1'b0, $sformatf("%s tick %0d", what, i));
    end
  endtask

  task automatic clr_sts();
    sts_clr_i = 1; cyc(); sts_clr_i = 0;
  endtask

  task automatic t_reset();
    chk(smi_req_o, 1'b0, "R1 smi after reset");
    chk(idle_sts_o, 1'b0, "R1 status after reset");
    ticks_none(3, "R1 stopped after reset");
  endtask

  task automatic t_basic();
    wr_init(8'd3);
    wr_run(1'b1);
    ticks_expect(3, "R3 count of 3");
    chk(idle_sts_o, 1'b1, "R4 status on expiry");
    cyc();
    chk(smi_req_o, 1'b0, "R4 smi is one cycle");
    ticks_expect(3, "R4 auto reload");
  endtask

  task automatic t_status();
    cyc(); cyc(); cyc();
    chk(idle_sts_o, 1'b1, "R5 status sticky");
    clr_sts();
    chk(idle_sts_o, 1'b0, "R5 status cleared");
  endtask

  task automatic t_freeze();
    logic s;
    wr_init(8'd2);
    wr_run(1'b1);
    one_tick(s);
    chk(s, 1'b0, "R9 first tick");
    freeze_i = 1;
    ticks_none(5, "R9 frozen");
    freeze_i = 0;
    one_tick(s);
    chk(s, 1'b1, "R9 resume from held count");
  endtask

  task automatic t_event_on();
    wr_init(8'd3);
    wr_run(1'b1);
    ticks_none(2, "R6 before event");
    evt_en_i = '0; evt_en_i[4] = 1; evt_all_en_i = 1;
    evt_i[4] = 1; cyc(); evt_i[4] = 0;
    ticks_expect(3, "R6 enabled event reloads");
  endtask

  task automatic t_event_masked();
    logic s;
    wr_run(1'b1);
    ticks_none(2, "R7 before masked event");
    evt_en_i = '0; evt_en_i[5] = 1; evt_all_en_i = 1;
    evt_i[4] = 1; cyc(); evt_i[4] = 0;
    one_tick(s);
    chk(s, 1'b1, "R7 disabled line no reload");
    ticks_none(2, "R7 after expiry");
    evt_en_i[4] = 1; evt_all_en_i = 0;
    evt_i[4] = 1; cyc(); evt_i[4] = 0;
    one_tick(s);
    chk(s, 1'b1, "R7 global off no reload");
  endtask

  task automatic t_activity();
    evt_all_en_i = 0; evt_en_i = '0;
    wr_run(1'b1);
    ticks_none(2, "R8 before activity");
    activity_i = 1; cyc(); activity_i = 0;
    ticks_expect(3, "R8 activity reloads");
  endtask

  task automatic t_priority();
    logic s;
    wr_run(1'b1);
    ticks_none(2, "R10 before");
    tick_i = 1; activity_i = 1; cyc(); tick_i = 0; activity_i = 0;
    chk(smi_req_o, 1'b0, "R10 no expiry on reload+tick");
    ticks_expect(3, "R10 tick lost to reload");
    evt_en_i = '0; evt_en_i[0] = 1; evt_all_en_i = 1;
    ticks_none(2, "R10 event before");
    tick_i = 1; evt_i[0] = 1; cyc(); tick_i = 0; evt_i[0] = 0;
    one_tick(s);
    chk(s, 1'b0, "R10 event+tick reload");
    ticks_expect(2, "R10 event+tick remaining");
  endtask

  task automatic t_start_bypass();
    init_we_i = 1; init_wdata_i = 8'd5; run_we_i = 1; run_wdata_i = 1;
    cyc();
    init_we_i = 0; run_we_i = 0;
    ticks_expect(5, "R2 same-cycle init value");
    ticks_none(2, "R2 restart part");
    wr_run(1'b1);
    ticks_expect(5, "R2 run write reloads");
  endtask

  task automatic t_zero();
    wr_init(8'd0);
    wr_run(1'b1);
    ticks_expect(1, "R3 zero count");
    ticks_expect(1, "R3 zero count again");
  endtask

  task automatic t_stop();
    wr_init(8'd2);
    wr_run(1'b1);
    ticks_none(1, "R11 before stop");
    wr_run(1'b0);
    ticks_none(6, "R11 stopped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_status();
    t_freeze();
    t_event_on();
    t_event_masked();
    t_activity();
    t_priority();
    t_start_bypass();
    t_zero();
    clr_sts();
    t_stop();
    chk(idle_sts_o, 1'b0, "R5 stays clear while stopped");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule